// File: doc/BRIEF.md
# Luma One-Bit Threshold Packer

This block sits in a video capture path between the sensor sample stream and the memory writer. It receives one sample per handshake, each flagged as luma or chroma and optionally marked as the first or last sample of a line. Chroma samples are consumed and thrown away. In one-bit mode each luma sample is compared against a programmable 8-bit threshold and becomes a single bit, and 32 such bits are gathered into each output word. In byte mode the block instead gathers four raw 8-bit luma samples per word.

A line that ends partway through a word is closed with zero fill, so the next line always begins in a new word and the memory writer can place every line at a word-aligned address. The output uses a valid/ready handshake. While a finished word is waiting to be taken, the input is held off. The packing mode is taken from the configuration input only when a line starts.

Top module: `luma_bit_packer`

## Requirements
- R1: In one-bit mode a luma sample gives bit value 1 when the sample is greater than or equal to `cfg_thresh`, and 0 when it is smaller.
- R2: In one-bit mode (`cfg_bin_en`=1 at line start) 32 luma samples make one word. The first sample of the word lands in bit 0, and later samples fill bits 1, 2, ... in order.
- R3: A sample with `in_chroma`=1 is accepted and dropped. Its data, start marker and end marker have no effect on any output word.
- R4: An accepted luma sample with `in_eol`=1 closes the current word at once. Unused bit positions are zero, `out_last` is 1 on that word, and the next luma sample starts a new word.
- R5: In byte mode (`cfg_bin_en`=0 at line start) four luma samples make one word. Sample k of the word (k=0..3) occupies bits [8k+7:8k].
- R6: The mode is captured when a luma sample with `in_sol`=1 is accepted. Changes to `cfg_bin_en` at any other time do not affect the rest of that line.
- R7: A luma sample with `in_sol`=1 discards any partial word left by a line that had no end marker. Words that were already complete are still output, each with `out_last`=0.
- R8: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data` and `out_last` hold their values.
- R9: `in_ready` is 0 while a word is waiting with `out_ready`=0. Every accepted luma sample reaches an output word, and no word is lost or duplicated.
- R10: After reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_bin_en | input | 1 | 1 = one-bit mode, 0 = byte mode; sampled at line start |
| cfg_thresh | input | PIX_W | Binarization threshold |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted this cycle when high with in_valid |
| in_luma | input | PIX_W | Sample value |
| in_chroma | input | 1 | Sample is chroma and is to be dropped |
| in_sol | input | 1 | First sample of a line |
| in_eol | input | 1 | Last sample of a line |
| out_valid | output | 1 | Packed word valid |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | WORD_W | Packed word |
| out_last | output | 1 | Word is the last of its line |

## Verification
The hardest situation to reach from the ports is a word that completes while the output is stalled. This happens when a full word or an end-of-line flush is ready while a previous word still sits unaccepted. It has to coincide with mode changes and with lines cut short by a new start marker. The bench drives random 8-bit luma close to the threshold and mixes in chroma samples that carry stray markers. It uses a random `out_ready` with periodic long stall windows, so that completion and backpressure often meet. Directed lines of exactly 32, 33 and 5 samples, threshold edges at 0 and 255, a mid-line mode toggle and a truncated line cover the edges of the packing.

// File: rtl/luma_pack_pkg.sv
`timescale 1ns/1ps
package luma_pack_pkg;
  // Packing mode captured at each line start
  typedef enum logic {
    PACK_BYTE = 1'b0,
    PACK_BIT  = 1'b1
  } pack_mode_e;
endpackage

// File: rtl/lpk_quantizer.sv
`timescale 1ns/1ps
// Converts one luma sample to its lane contribution in a word.
module lpk_quantizer
  import luma_pack_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 8,
  parameter int IDX_W  = $clog2(WORD_W)
) (
  input  logic [PIX_W-1:0]  luma,
  input  logic [PIX_W-1:0]  thresh,
  input  pack_mode_e        mode,
  input  logic [IDX_W-1:0]  lane,
  output logic [WORD_W-1:0] placed
);
  localparam int BYTE_LANES = WORD_W / PIX_W;

  // Binarization rule: at or above threshold is a one
  function automatic logic luma_to_bit(input logic [PIX_W-1:0] y,
                                       input logic [PIX_W-1:0] t);
    return (y >= t);
  endfunction

  logic              pix_bit;
  logic [WORD_W-1:0] bit_word;
  logic [WORD_W-1:0] byte_word;

  assign pix_bit = luma_to_bit(luma, thresh);

  for (genvar g = 0; g < WORD_W; g++) begin : g_bit_lane
    assign bit_word[g] = pix_bit && (lane == IDX_W'(g));
  end

  for (genvar b = 0; b < BYTE_LANES; b++) begin : g_byte_lane
    assign byte_word[b*PIX_W +: PIX_W] = (lane == IDX_W'(b)) ? luma : '0;
  end

  if (BYTE_LANES * PIX_W < WORD_W) begin : g_byte_pad
    assign byte_word[WORD_W-1:BYTE_LANES*PIX_W] = '0;
  end

  assign placed = (mode == PACK_BIT) ? bit_word : byte_word;
endmodule

// File: rtl/lpk_word_assembler.sv
`timescale 1ns/1ps
// Gathers lane contributions into a word, closes it when full or at line end.
module lpk_word_assembler
  import luma_pack_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 8,
  parameter int IDX_W  = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_fire,
  input  logic              in_chroma,
  input  logic              in_sol,
  input  logic              in_eol,
  input  pack_mode_e        cfg_mode,
  input  logic [WORD_W-1:0] placed,
  output logic [IDX_W-1:0]  lane_idx,
  output pack_mode_e        lane_mode,
  output logic              emit,
  output logic [WORD_W-1:0] emit_data,
  output logic              emit_last
);
  localparam int BYTE_LANES = WORD_W / PIX_W;

  logic [WORD_W-1:0] acc_q;
  logic [IDX_W-1:0]  cnt_q;
  pack_mode_e        mode_q;

  logic              luma_fire;
  logic              chroma_fire;
  logic              luma_sol;
  logic [IDX_W-1:0]  last_lane;
  logic [WORD_W-1:0] merged;
  logic              word_done;

  assign luma_fire   = in_fire && !in_chroma;
  assign chroma_fire = in_fire && in_chroma;
  assign luma_sol    = in_sol && !in_chroma;

  always_comb begin
    lane_mode = luma_sol ? cfg_mode : mode_q;
    lane_idx  = luma_sol ? '0 : cnt_q;
    last_lane = (lane_mode == PACK_BIT) ? IDX_W'(WORD_W - 1) : IDX_W'(BYTE_LANES - 1);
    merged    = (luma_sol ? '0 : acc_q) | placed;
    word_done = luma_fire && ((lane_idx == last_lane) || in_eol);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      cnt_q  <= '0;
      mode_q <= PACK_BYTE;
    end else if (luma_fire) begin
      if (luma_sol) mode_q <= cfg_mode;
      if (word_done) begin
        acc_q <= '0;
        cnt_q <= '0;
      end else begin
        acc_q <= merged;
        cnt_q <= lane_idx + IDX_W'(1);
      end
    end
  end

  assign emit      = word_done;
  assign emit_data = merged;
  assign emit_last = in_eol;

  // R6: the captured mode moves only at a luma line start
  a_r6_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(luma_fire && luma_sol) |=> $stable(mode_q));
  // R3: chroma samples leave the partial word untouched
  a_r3_chroma_inert: assert property (@(posedge clk) disable iff (!rst_n)
    chroma_fire |=> ($stable(acc_q) && $stable(cnt_q)));
  // R4: a line end leaves an empty word behind
  a_r4_fresh_line: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && in_eol) |=> (cnt_q == '0 && acc_q == '0));
  // R5: byte mode never fills beyond its last byte lane
  a_r5_byte_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == PACK_BYTE) |-> (cnt_q <= IDX_W'(BYTE_LANES - 1)));
endmodule

// File: rtl/lpk_out_stage.sv
`timescale 1ns/1ps
// Single holding register for the finished word.
module lpk_out_stage #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_data,
  input  logic              load_last,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last,
  output logic              slot_free
);
  assign slot_free = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
      out_last  <= load_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R8: a waiting word is frozen until taken
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
endmodule

// File: rtl/luma_bit_packer.sv
`timescale 1ns/1ps
module luma_bit_packer
  import luma_pack_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_bin_en,
  input  logic [PIX_W-1:0]  cfg_thresh,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [PIX_W-1:0]  in_luma,
  input  logic              in_chroma,
  input  logic              in_sol,
  input  logic              in_eol,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_last
);
  localparam int IDX_W = $clog2(WORD_W);

  logic              slot_free;
  logic              in_fire;
  logic [IDX_W-1:0]  lane_idx;
  pack_mode_e        lane_mode;
  logic [WORD_W-1:0] placed;
  logic              emit;
  logic [WORD_W-1:0] emit_data;
  logic              emit_last;

  assign in_ready = slot_free;
  assign in_fire  = in_valid && slot_free;

  lpk_quantizer #(.WORD_W(WORD_W), .PIX_W(PIX_W), .IDX_W(IDX_W)) u_quant (
    .luma   (in_luma),
    .thresh (cfg_thresh),
    .mode   (lane_mode),
    .lane   (lane_idx),
    .placed (placed)
  );

  lpk_word_assembler #(.WORD_W(WORD_W), .PIX_W(PIX_W), .IDX_W(IDX_W)) u_asm (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_fire   (in_fire),
    .in_chroma (in_chroma),
    .in_sol    (in_sol),
    .in_eol    (in_eol),
    .cfg_mode  (pack_mode_e'(cfg_bin_en)),
    .placed    (placed),
    .lane_idx  (lane_idx),
    .lane_mode (lane_mode),
    .emit      (emit),
    .emit_data (emit_data),
    .emit_last (emit_last)
  );

  lpk_out_stage #(.WORD_W(WORD_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (emit),
    .load_data (emit_data),
    .load_last (emit_last),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last),
    .slot_free (slot_free)
  );

  // R9: every closed word lands in the output register unchanged
  a_r9_word_lands: assert property (@(posedge clk) disable iff (!rst_n)
    emit |=> (out_valid && out_data == $past(emit_data) && out_last == $past(emit_last)));
endmodule

// File: tb/luma_bit_packer_tb.sv
`timescale 1ns/1ps
module luma_bit_packer_tb;
  localparam int WW = 32;
  localparam int PW = 8;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_bin_en = 1'b0;
  logic [PW-1:0] cfg_thresh = '0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [PW-1:0] in_luma = '0;
  logic in_chroma = 1'b0, in_sol = 1'b0, in_eol = 1'b0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [WW-1:0] out_data;
  logic out_last;

  always #2 clk = ~clk;

  luma_bit_packer #(.WORD_W(WW), .PIX_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_bin_en(cfg_bin_en), .cfg_thresh(cfg_thresh),
    .in_valid(in_valid), .in_ready(in_ready), .in_luma(in_luma),
    .in_chroma(in_chroma), .in_sol(in_sol), .in_eol(in_eol),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  typedef struct {
    int    y;
    bit    chroma, sol, eol, mode, drive;
    int    thr;
    string tag;
  } rec_t;

  typedef struct {
    logic [WW-1:0] d;
    bit            l;
    string         tag;
  } exp_t;

  rec_t  stim[$];
  exp_t  expq[$];
  int    lb[$];
  int    lt[$];
  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [WW-1:0] act,
                       input logic [WW-1:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic push_rec(input int y, input bit chroma, input bit sol, input bit eol,
                          input bit mode, input bit drive, input int thr, input string tag);
    rec_t r;
    r.y = y; r.chroma = chroma; r.sol = sol; r.eol = eol;
    r.mode = mode; r.drive = drive; r.thr = thr; r.tag = tag;
    stim.push_back(r);
  endtask

  // A line of n luma samples with optional chroma, mode toggling and missing end
  task automatic add_line(input int n, input bit mode, input int thr, input bit ended,
                          input int chroma_pct, input bit toggle, input string tag);
    for (int i = 0; i < n; i++) begin
      int y;
      if ((($urandom % 100) < chroma_pct))
        push_rec($urandom % 256, 1'b1, $urandom % 2, $urandom % 2, mode, $urandom % 2,
                 $urandom % 256, tag);
      if ($urandom % 2) y = $urandom % 256;
      else begin
        y = thr + int'($urandom % 3) - 1;
        if (y < 0) y = 0;
        if (y > 255) y = 255;
      end
      push_rec(y, 1'b0, i == 0, ended && (i == n - 1), mode,
               (toggle && i > 0) ? !mode : mode, thr, tag);
    end
  endtask

  // Expected words of one line buffered in lb/lt
  task automatic flush_line(input bit ended, input bit mode, input string tag);
    int lanes, n, nw;
    lanes = mode ? WW : WW / PW;
    n = lb.size();
    nw = ended ? (n + lanes - 1) / lanes : n / lanes;
    for (int k = 0; k < nw; k++) begin
      exp_t e;
      e.d = '0;
      for (int j = 0; j < lanes; j++) begin
        int p;
        p = k * lanes + j;
        if (p < n) begin
          if (mode) e.d[j] = (lb[p] >= lt[p]);
          else e.d[PW*j +: PW] = PW'(lb[p]);
        end
      end
      e.l = ended && (k == nw - 1);
      if (tag != "") e.tag = tag;
      else if (e.l && (n % lanes) != 0) e.tag = "R4";
      else e.tag = mode ? "R2" : "R5";
      expq.push_back(e);
    end
    lb.delete();
    lt.delete();
  endtask

  task automatic build_expected();
    bit    cur_mode;
    string cur_tag;
    cur_mode = 1'b0;
    cur_tag = "";
    foreach (stim[i]) begin
      if (!stim[i].chroma) begin
        if (stim[i].sol) begin
          if (lb.size() > 0) flush_line(1'b0, cur_mode, cur_tag);
          cur_mode = stim[i].mode;
          cur_tag = stim[i].tag;
        end
        lb.push_back(stim[i].y);
        lt.push_back(stim[i].thr);
        if (stim[i].eol) flush_line(1'b1, cur_mode, cur_tag);
      end
    end
    lb.delete();
    lt.delete();
  endtask

  initial begin
    #(LIMIT * 4);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog R9 actual=%0d expected=%0d", expq.size(), 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int  idx;
    bit  hold;
    bit  prev_stall;
    logic [WW-1:0] prev_data;
    bit  prev_last;
    int  cyc;
    void'($urandom(32'd20240611));

    // Directed lines
    add_line(32, 1'b1, 100, 1'b1, 0, 1'b0, "R2");
    add_line(33, 1'b1, 90, 1'b1, 0, 1'b0, "R4");
    add_line(5, 1'b0, 0, 1'b1, 0, 1'b0, "R4");
    add_line(8, 1'b0, 0, 1'b1, 0, 1'b0, "R5");
    add_line(10, 1'b1, 0, 1'b1, 0, 1'b0, "R1");
    for (int i = 0; i < 6; i++)
      push_rec((i % 2) ? 254 : 255, 1'b0, i == 0, i == 5, 1'b1, 1'b1, 255, "R1");
    for (int i = 0; i < 3; i++)
      push_rec(127 + i, 1'b0, i == 0, i == 2, 1'b1, 1'b1, 128, "R1");
    add_line(40, 1'b1, 60, 1'b1, 40, 1'b0, "R3");
    add_line(9, 1'b0, 0, 1'b1, 40, 1'b0, "R3");
    add_line(20, 1'b1, 70, 1'b1, 0, 1'b1, "R6");
    add_line(11, 1'b0, 0, 1'b1, 0, 1'b1, "R6");
    add_line(70, 1'b1, 128, 1'b0, 0, 1'b0, "R7");
    add_line(6, 1'b0, 0, 1'b0, 0, 1'b0, "R7");
    // Random lines
    for (int l = 0; l < 60; l++)
      add_line(1 + ($urandom % 80), $urandom % 2, $urandom % 256,
               ($urandom % 10) != 0, (($urandom % 3) == 0) ? 25 : 0,
               ($urandom % 10) == 0, "");
    add_line(7, 1'b1, 50, 1'b1, 0, 1'b0, "");
    build_expected();

    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R10 out_valid after reset", WW'(out_valid), '0);
    check(in_ready == 1'b1, "R10 in_ready after reset", WW'(in_ready), WW'(1));
    rst_n = 1'b1;

    idx = 0; hold = 1'b0; prev_stall = 1'b0; prev_data = '0; prev_last = 1'b0; cyc = 0;
    while ((idx < stim.size() || expq.size() > 0) && cyc < LIMIT - 1000) begin
      @(negedge clk);
      cyc++;
      if (idx < stim.size()) begin
        if (!hold) in_valid = ($urandom % 4) != 0;
        in_luma    = PW'(stim[idx].y);
        in_chroma  = stim[idx].chroma;
        in_sol     = stim[idx].sol;
        in_eol     = stim[idx].eol;
        cfg_bin_en = stim[idx].drive;
        cfg_thresh = PW'(stim[idx].thr);
      end else begin
        in_valid = 1'b0;
      end
      if ((cyc % 400) < 25) out_ready = 1'b0;
      else out_ready = ($urandom % 3) != 0;
      #1;
      if (prev_stall && out_valid)
        check(out_data == prev_data && out_last == prev_last, "R8 held word",
              out_data, prev_data);
      else if (prev_stall)
        check(1'b0, "R8 valid dropped while stalled", WW'(out_valid), WW'(1));
      if (out_valid && !out_ready)
        check(in_ready == 1'b0, "R9 input stalled", WW'(in_ready), '0);
      if (out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R9 unexpected word", out_data, '0);
        end else begin
          exp_t e;
          e = expq.pop_front();
          check(out_data == e.d, {e.tag, " data"}, out_data, e.d);
          check(out_last == e.l, {e.tag, " last"}, WW'(out_last), WW'(e.l));
        end
      end
      prev_stall = out_valid && !out_ready;
      prev_data = out_data;
      prev_last = out_last;
      if (in_valid && in_ready) begin
        idx++;
        hold = 1'b0;
      end else begin
        hold = in_valid;
      end
    end
    in_valid = 1'b0;
    check(expq.size() == 0, "R9 all words delivered", WW'(expq.size()), '0);
    check(idx == stim.size(), "R9 all samples taken", WW'(idx), WW'(stim.size()));
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule